// File: doc/BRIEF.md
# Board Overtemperature Supervisor

This block watches a digitized board temperature and guards a group of power outputs with two levels of protection. Samples arrive as signed values in half-degree steps, each marked by a valid strobe. A slow time-base tick runs a grace counter. When a sample goes above the soft limit, the active-low warning line drops and the grace counter starts. The outputs stay on during this time. If the board is still hot when the grace period ends, the outputs are switched off. A sample at or above the hard limit switches them off at once, whatever the counter holds.

Both kinds of shutdown clear only when a sample arrives below a lower restart threshold. The outputs then come back on by themselves and the warning line goes high again. The gap between the restart threshold and the soft limit is hysteresis, so the warning line does not toggle quickly near the limit. The thresholds and the grace length are parameters. By default they are 115 °C soft, 125 °C hard, 110 °C restart and 30 ticks, where one tick per second is assumed.

Top module: `thermal_guard`

## Requirements
- R1: After reset, warn_n is 1, out_en is 1 and status is 2'b00 (running).
- R2: In running, a valid sample strictly greater than SOFT_LIM (temperature in signed 0.5 °C units, 230 = 115 °C) drives warn_n low and status to 2'b01 (warning) on the next cycle, and out_en stays 1. A sample equal to SOFT_LIM changes nothing.
- R3: In warning, a valid sample strictly below RESTART_LIM (220 = 110 °C) returns the block to running: warn_n goes to 1 and status to 2'b00. A sample equal to RESTART_LIM leaves the block in warning.
- R4: In warning, once GRACE_TICKS ticks have been counted and the most recent sample is above SOFT_LIM, out_en goes to 0 and status goes to 2'b10 (timed trip). With fewer ticks, out_en stays 1.
- R5: A valid sample at or above HARD_LIM (250 = 125 °C) moves the block from any state to status 2'b11 (hard trip) with out_en 0 on the next cycle, whatever the grace count.
- R6: In either trip state, warn_n stays 0 and out_en stays 0 until a valid sample strictly below RESTART_LIM arrives. That sample returns the block to running with warn_n 1 and out_en 1.
- R7: Temperature values presented while valid is low have no effect.
- R8: The grace count is cleared whenever the block leaves warning, so a new warning starts a full grace period.
- R9: When the grace count has just expired and a valid sample arrives in that same cycle, the sample decides the result. Below RESTART_LIM gives running, above SOFT_LIM gives timed trip, and a value between the two leaves the block in warning.
- R10: Ticks have no effect outside warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_valid | input | 1 | Marks temp_data as a new sample |
| temp_data | input | 10 | Signed temperature in 0.5 °C steps |
| tick | input | 1 | One-cycle time-base pulse for the grace counter |
| warn_n | output | 1 | Low while over temperature or tripped |
| out_en | output | 1 | High while the power outputs may be on |
| status | output | 2 | 00 running, 01 warning, 10 timed trip, 11 hard trip |

## Verification
Grace expiry and a new temperature sample can fall in the same cycle, and the design has to choose between them. The bench provokes this by raising the final tick and then presenting a sample in the very next cycle, which is the cycle in which the expired count is first seen. It uses three sample values: one below the restart threshold, one above the soft limit and one in the hysteresis band. The bench judges the result from status and out_en one cycle later, against running, timed trip and warning in that order. A separate case checks that the hard limit wins over an unexpired count.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    localparam int TEMP_W = 10;

    typedef logic signed [TEMP_W-1:0] temp_t;

    typedef enum logic [1:0] {
        ST_RUN        = 2'b00,
        ST_WARN       = 2'b01,
        ST_TRIP_TIMER = 2'b10,
        ST_TRIP_HARD  = 2'b11
    } guard_state_e;

    typedef struct packed {
        logic hot;    // above soft limit
        logic hard;   // at or above hard limit
        logic cool;   // below restart limit
    } temp_flags_t;

    function automatic logic is_tripped(guard_state_e s);
        return (s == ST_TRIP_TIMER) || (s == ST_TRIP_HARD);
    endfunction

endpackage

// File: rtl/thermal_cmp.sv
module thermal_cmp
    import thermal_guard_pkg::*;
#(
    parameter int SOFT_LIM    = 230,
    parameter int HARD_LIM    = 250,
    parameter int RESTART_LIM = 220
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid_i,
    input  temp_t       temp_i,
    output temp_flags_t flags_o
);

    always_comb begin
        flags_o.hot  = valid_i && (temp_i >  SOFT_LIM);
        flags_o.hard = valid_i && (temp_i >= HARD_LIM);
        flags_o.cool = valid_i && (temp_i <  RESTART_LIM);
    end

    AST_HARD_IMPLIES_HOT: assert property (@(posedge clk) disable iff (rst)
        flags_o.hard |-> flags_o.hot) else $error("hard without hot"); // R5

    AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> (flags_o == '0)) else $error("flag without valid"); // R7

endmodule

// File: rtl/grace_timer.sv
module grace_timer #(
    parameter int GRACE_TICKS = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic expired_o
);

    localparam int CNT_W = $clog2(GRACE_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GRACE_TICKS);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == CNT_MAX);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX) else $error("grace count overflow"); // R4

    AST_CLEAR_OFF_WARN: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0)) else $error("count not cleared"); // R8

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import thermal_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         valid_i,
    input  temp_flags_t  flags_i,
    input  logic         expired_i,
    output guard_state_e state_o
);

    guard_state_e state_q, state_d;
    logic         hot_q;
    logic         hot_now;

    // latest known "above soft limit" status
    assign hot_now = valid_i ? flags_i.hot : hot_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (flags_i.hard)     state_d = ST_TRIP_HARD;
                else if (flags_i.hot) state_d = ST_WARN;
            end
            ST_WARN: begin
                if (flags_i.hard)              state_d = ST_TRIP_HARD;
                else if (flags_i.cool)         state_d = ST_RUN;
                else if (expired_i && hot_now) state_d = ST_TRIP_TIMER;
            end
            ST_TRIP_TIMER: begin
                if (flags_i.hard)      state_d = ST_TRIP_HARD;
                else if (flags_i.cool) state_d = ST_RUN;
            end
            ST_TRIP_HARD: begin
                if (flags_i.cool) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            hot_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (valid_i) hot_q <= flags_i.hot;
        end
    end

    assign state_o = state_q;

    AST_HARD_TRIPS: assert property (@(posedge clk) disable iff (rst)
        flags_i.hard |=> (state_q == ST_TRIP_HARD)) else $error("hard limit missed"); // R5

    AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (is_tripped(state_q) && !flags_i.cool) |=> is_tripped(state_q)) else $error("trip released early"); // R6

    AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WARN && !expired_i && !flags_i.hard) |=> !is_tripped(state_q)) else $error("trip before grace end"); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !(state_q == ST_WARN && expired_i)) |=> $stable(state_q)) else $error("state moved without sample"); // R7

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int SOFT_LIM    = 230,
    parameter int HARD_LIM    = 250,
    parameter int RESTART_LIM = 220,
    parameter int GRACE_TICKS = 30
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    temp_valid,
    input  logic signed [TEMP_W-1:0] temp_data,
    input  logic                    tick,
    output logic                    warn_n,
    output logic                    out_en,
    output logic [1:0]              status
);

    temp_flags_t  flags;
    logic         expired;
    guard_state_e state;

    thermal_cmp #(
        .SOFT_LIM    (SOFT_LIM),
        .HARD_LIM    (HARD_LIM),
        .RESTART_LIM (RESTART_LIM)
    ) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .valid_i (temp_valid),
        .temp_i  (temp_data),
        .flags_o (flags)
    );

    grace_timer #(
        .GRACE_TICKS (GRACE_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .run_i     (state == ST_WARN),
        .tick_i    (tick),
        .expired_o (expired)
    );

    guard_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (temp_valid),
        .flags_i   (flags),
        .expired_i (expired),
        .state_o   (state)
    );

    assign warn_n = (state == ST_RUN);
    assign out_en = !is_tripped(state);
    assign status = state;

    AST_SHUT_WARN_LOW: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> !warn_n) else $error("trip with warning high"); // R6

    AST_WARN_KEEPS_POWER: assert property (@(posedge clk) disable iff (rst)
        (warn_n && !(temp_valid && temp_data >= HARD_LIM)) |=> out_en) else $error("power lost from run"); // R2

endmodule

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb;

    localparam int SOFT  = 230;
    localparam int HARD  = 250;
    localparam int RST_T = 220;
    localparam int GRACE = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic temp_valid = 1'b0;
    logic signed [9:0] temp_data = '0;
    logic tick = 1'b0;
    logic warn_n, out_en;
    logic [1:0] status;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    thermal_guard #(
        .SOFT_LIM(SOFT), .HARD_LIM(HARD), .RESTART_LIM(RST_T), .GRACE_TICKS(GRACE)
    ) u_dut (
        .clk(clk), .rst(rst), .temp_valid(temp_valid), .temp_data(temp_data),
        .tick(tick), .warn_n(warn_n), .out_en(out_en), .status(status)
    );

    task automatic chk(string req, logic ew, logic ee, logic [1:0] es);
        n_run++;
        if (warn_n !== ew || out_en !== ee || status !== es) begin
            n_fail++;
            $display("FAIL %s: warn_n/out_en/status = %b/%b/%b expected %b/%b/%b",
                     req, warn_n, out_en, status, ew, ee, es);
        end
    endtask

    task automatic send(int t);
        @(negedge clk);
        temp_valid = 1'b1;
        temp_data  = 10'(t);
        @(negedge clk);
        temp_valid = 1'b0;
    endtask

    task automatic pulse_ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset", 1, 1, 2'b00);
    endtask

    task automatic t_soft_entry();
        do_reset();
        send(SOFT);
        chk("R2 equal soft ignored", 1, 1, 2'b00);
        send(SOFT + 1);
        chk("R2 above soft warns", 0, 1, 2'b01);
    endtask

    task automatic t_cool_early();
        do_reset();
        send(SOFT + 2);
        pulse_ticks(GRACE - 2);
        send(RST_T);
        chk("R3 equal restart stays warning", 0, 1, 2'b01);
        send(RST_T - 1);
        chk("R3 below restart clears", 1, 1, 2'b00);
    endtask

    task automatic t_grace();
        do_reset();
        send(SOFT + 4);
        pulse_ticks(GRACE - 1);
        @(negedge clk);
        chk("R4 short of grace keeps power", 0, 1, 2'b01);
        pulse_ticks(1);
        @(negedge clk);
        chk("R4 grace expiry trips", 0, 0, 2'b10);
        pulse_ticks(3);
        send(SOFT);
        chk("R6 trip holds in band", 0, 0, 2'b10);
        send(RST_T - 1);
        chk("R6 restart below threshold", 1, 1, 2'b00);
    endtask

    task automatic t_hard();
        do_reset();
        send(HARD);
        chk("R5 hard from running", 0, 0, 2'b11);
        send(RST_T);
        chk("R6 hard trip holds at restart value", 0, 0, 2'b11);
        send(RST_T - 20);
        chk("R6 hard trip restarts", 1, 1, 2'b00);
        send(SOFT + 1);
        pulse_ticks(1);
        send(HARD + 5);
        chk("R5 hard overrides unexpired grace", 0, 0, 2'b11);
    endtask

    task automatic t_ignore();
        do_reset();
        @(negedge clk);
        temp_data = 10'(HARD + 10);
        repeat (3) @(negedge clk);
        chk("R7 invalid sample ignored", 1, 1, 2'b00);
        pulse_ticks(GRACE + 2);
        send(SOFT + 1);
        pulse_ticks(GRACE - 1);
        @(negedge clk);
        chk("R10 ticks in running not counted", 0, 1, 2'b01);
    endtask

    task automatic t_clear();
        do_reset();
        send(SOFT + 1);
        pulse_ticks(GRACE - 1);
        send(RST_T - 1);
        send(SOFT + 1);
        pulse_ticks(GRACE - 1);
        @(negedge clk);
        chk("R8 count restarts on new warning", 0, 1, 2'b01);
    endtask

    task automatic collide(int t, string req, logic ew, logic ee, logic [1:0] es);
        do_reset();
        send(SOFT + 3);
        pulse_ticks(GRACE - 1);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        temp_valid = 1'b1;
        temp_data = 10'(t);
        @(negedge clk);
        temp_valid = 1'b0;
        chk(req, ew, ee, es);
    endtask

    initial begin
        #2000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_soft_entry();
        t_cool_early();
        t_grace();
        t_hard();
        t_ignore();
        t_clear();
        collide(RST_T - 1, "R9 cool sample at expiry", 1, 1, 2'b00);
        collide(SOFT + 1,  "R9 hot sample at expiry",  0, 0, 2'b10);
        collide(SOFT - 4,  "R9 band sample at expiry", 0, 1, 2'b01);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule